// File: doc/BRIEF.md
# Timer Capture Input Conditioner

This block turns one timer channel's raw input pin into a stream of capture strobes. The pin is first brought into the clock domain by a two-flop synchroniser. It then passes a glitch filter that only accepts a new level after that level has been seen on several consecutive filter sample ticks. A registered edge detector follows, and a polarity bit picks the rising or the falling transition as this channel's trigger.

A two-bit source code chooses what drives the capture path. The choices are this channel's own edge, the edge of the neighbouring channel (given as separate rise and fall pulses and qualified by the same polarity bit), or a trigger line from a slave controller. The chosen events go through a power-of-two event divider. A channel enable then lets the divided events out as one-clock capture strobes. A separate registered pulse marks every transition of the filtered level, for use by a slave controller.

All configuration is plain input ports. Bus access, the counter and the capture register sit outside this block.

Top module: `tmr_capture_path`

## Requirements
- R1: While rst_n is low and in the first clock after it rises, filt_lvl, edge_evt and cap_strobe are 0.
- R2: With flt_cfg = 0, a change on pin_in shows on filt_lvl 3 clocks later. A resulting edge_evt or own-source cap_strobe appears 4 clocks after the pin change.
- R3: With flt_cfg = N > 0, filt_lvl takes a new level only after the synchronised pin has differed from it on N+1 consecutive smp_tick clocks. A shorter excursion leaves filt_lvl unchanged.
- R4: With flt_cfg nonzero and smp_tick low, filt_lvl holds its value whatever pin_in does.
- R5: edge_evt is a one-clock pulse, one clock after every change of filt_lvl, for both directions, regardless of polarity, source or enable.
- R6: pol_fall = 0 selects rising transitions and pol_fall = 1 selects falling transitions. This applies to both the own edge and the neighbour pulses (nbr_rise, nbr_fall).
- R7: src_sel = 01 takes the own filtered edge, 10 takes the neighbour edge, and 11 takes trig_in. trig_in is not affected by pol_fall.
- R8: With src_sel = 00 (output mode), cap_strobe stays 0 and the divider count is cleared.
- R9: div_sel values 00, 01, 10 and 11 emit a cap_strobe on every 1st, 2nd, 4th and 8th selected event. The strobe comes one clock after the event that completes the count and lasts one clock.
- R10: With chan_en = 0, no strobe is produced and the divider count is cleared. A clock in which div_sel differs from its value in the previous clock also clears the count, and that clock's event is dropped. The first event after either case is counted from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_tick | input | 1 | Filter sample enable, one clock wide per sample |
| pin_in | input | 1 | Raw asynchronous channel input |
| flt_cfg | input | FLT_W | Filter length setting (0 = no filtering) |
| pol_fall | input | 1 | Edge polarity: 0 rising, 1 falling |
| src_sel | input | 2 | Capture source code (00 output mode) |
| div_sel | input | DIV_W | Event divider setting, divide by 2^div_sel |
| chan_en | input | 1 | Channel capture enable |
| nbr_rise | input | 1 | Neighbour channel filtered rising-edge pulse |
| nbr_fall | input | 1 | Neighbour channel filtered falling-edge pulse |
| trig_in | input | 1 | Trigger pulse from the slave controller |
| filt_lvl | output | 1 | Filtered input level |
| edge_evt | output | 1 | Pulse on any filtered transition |
| cap_strobe | output | 1 | One-clock capture strobe |

## Verification
The bench builds the block with its defaults, FLT_W = 4 and DIV_W = 2. With these values every divide ratio up to 8 and any filter length up to 15 ticks fit in short runs. A vector table drives the neighbour and trigger paths through every source code, both polarities, each divide ratio and the clearing cases. Directed sequences then time the pin path through the synchroniser and the filter, and check rejection of a glitch one tick too short as well as the filter holding while sample ticks are withheld.

// File: rtl/tmr_capture_path.sv
module tmr_capture_path #(
  parameter int FLT_W = 4,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_tick,
  input  logic             pin_in,
  input  logic [FLT_W-1:0] flt_cfg,
  input  logic             pol_fall,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             chan_en,
  input  logic             nbr_rise,
  input  logic             nbr_fall,
  input  logic             trig_in,
  output logic             filt_lvl,
  output logic             edge_evt,
  output logic             cap_strobe
);

  localparam int PCNT_W = (1 << DIV_W) - 1;

  logic [1:0]       sync_q;
  logic             smp;
  logic             filt_q, filt_d1;
  logic [FLT_W-1:0] run_cnt;
  logic             rise, fall, own_evt, nbr_evt, sel_evt;
  logic [DIV_W-1:0] div_q;
  logic [PCNT_W-1:0] pcnt, mask;
  logic             clr, hit;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], pin_in};
  end

  assign smp = sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_q  <= 1'b0;
      run_cnt <= '0;
    end else if (flt_cfg == '0) begin
      filt_q  <= smp;
      run_cnt <= '0;
    end else if (smp_tick) begin
      if (smp == filt_q) begin
        run_cnt <= '0;
      end else if (run_cnt >= flt_cfg) begin
        filt_q  <= smp;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  assign rise    = filt_q & ~filt_d1;
  assign fall    = ~filt_q & filt_d1;
  assign own_evt = pol_fall ? fall : rise;
  assign nbr_evt = pol_fall ? nbr_fall : nbr_rise;

  always_comb begin
    case (src_sel)
      2'b01:   sel_evt = own_evt;
      2'b10:   sel_evt = nbr_evt;
      2'b11:   sel_evt = trig_in;
      default: sel_evt = 1'b0;
    endcase
  end

  assign mask = ~({PCNT_W{1'b1}} << div_sel);
  assign clr  = !chan_en || (src_sel == 2'b00) || (div_sel != div_q);
  assign hit  = sel_evt && !clr && (pcnt == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_d1    <= 1'b0;
      edge_evt   <= 1'b0;
      cap_strobe <= 1'b0;
      div_q      <= '0;
      pcnt       <= '0;
    end else begin
      filt_d1    <= filt_q;
      edge_evt   <= rise | fall;
      cap_strobe <= hit;
      div_q      <= div_sel;
      if (clr)          pcnt <= '0;
      else if (sel_evt) pcnt <= (pcnt == mask) ? '0 : pcnt + 1'b1;
    end
  end

  assign filt_lvl = filt_q;

  AST_OUTMODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b00) |=> !cap_strobe); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !cap_strobe); // R10
  AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_cfg != '0 && !smp_tick) |=> $stable(filt_lvl)); // R4
  AST_DIV1_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel == '0 && div_q == '0 && chan_en && src_sel == 2'b11 && trig_in) |=> cap_strobe); // R9

endmodule

// File: tb/tmr_capture_path_bench.sv
module tmr_capture_path_bench;

  logic       clk = 1'b0;
  logic       rst_n, smp_tick, pin_in, pol_fall, chan_en, nbr_rise, nbr_fall, trig_in;
  logic [3:0] flt_cfg;
  logic [1:0] src_sel, div_sel;
  logic       filt_lvl, edge_evt, cap_strobe;
  int         checks = 0, fails = 0;

  always #4 clk = ~clk;

  tmr_capture_path u_tmr_capture_path (
    .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .pin_in(pin_in),
    .flt_cfg(flt_cfg), .pol_fall(pol_fall), .src_sel(src_sel), .div_sel(div_sel),
    .chan_en(chan_en), .nbr_rise(nbr_rise), .nbr_fall(nbr_fall), .trig_in(trig_in),
    .filt_lvl(filt_lvl), .edge_evt(edge_evt), .cap_strobe(cap_strobe)
  );

  // fields: src[9:8] pol[7] div[6:5] en[4] nr[3] nf[2] trg[1] exp[0]
  localparam logic [9:0] VEC [0:35] = '{
    10'b10_0_00_1_1_0_0_1, 10'b10_0_00_1_0_1_0_0, 10'b10_1_00_1_0_1_0_1, 10'b10_1_00_1_1_0_0_0,
    10'b11_0_00_1_0_0_1_1, 10'b11_1_00_1_0_0_1_1, 10'b01_0_00_1_1_0_1_0, 10'b00_0_00_1_1_0_1_0,
    10'b11_0_00_0_0_0_1_0, 10'b11_0_01_1_0_0_0_0, 10'b11_0_01_1_0_0_1_0, 10'b11_0_01_1_0_0_1_1,
    10'b11_0_01_1_0_0_0_0, 10'b11_0_01_1_0_0_1_0, 10'b11_0_01_1_0_0_1_1, 10'b11_0_10_1_0_0_0_0,
    10'b11_0_10_1_0_0_1_0, 10'b11_0_10_1_0_0_1_0, 10'b11_0_10_1_0_0_1_0, 10'b11_0_10_1_0_0_1_1,
    10'b11_0_10_1_0_0_1_0, 10'b11_0_10_1_0_0_1_0, 10'b11_0_10_0_0_0_0_0, 10'b11_0_10_1_0_0_1_0,
    10'b11_0_10_1_0_0_1_0, 10'b11_0_10_1_0_0_1_0, 10'b11_0_10_1_0_0_1_1, 10'b11_0_11_1_0_0_0_0,
    10'b11_0_11_1_0_0_1_0, 10'b11_0_11_1_0_0_1_0, 10'b11_0_11_1_0_0_1_0, 10'b11_0_11_1_0_0_1_0,
    10'b11_0_11_1_0_0_1_0, 10'b11_0_11_1_0_0_1_0, 10'b11_0_11_1_0_0_1_0, 10'b11_0_11_1_0_0_1_1
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; smp_tick = 1; pin_in = 0; flt_cfg = 0; pol_fall = 0;
    src_sel = 2'b10; div_sel = 0; chan_en = 1; nbr_rise = 0; nbr_fall = 0; trig_in = 0;
    tick(3);
    chk("R1 filt_lvl", filt_lvl, 0); chk("R1 edge_evt", edge_evt, 0); chk("R1 cap_strobe", cap_strobe, 0);
    rst_n = 1;
    tick(1);
    chk("R1 cap_strobe after release", cap_strobe, 0);
    tick(2);

    for (int i = 0; i < 36; i++) begin
      src_sel = VEC[i][9:8]; pol_fall = VEC[i][7]; div_sel = VEC[i][6:5];
      chan_en = VEC[i][4]; nbr_rise = VEC[i][3]; nbr_fall = VEC[i][2]; trig_in = VEC[i][1];
      tick(1);
      chk($sformatf("R6/R7/R8/R9/R10 vector %0d", i), cap_strobe, VEC[i][0]);
    end
    nbr_rise = 0; nbr_fall = 0; trig_in = 0;
    src_sel = 2'b01; pol_fall = 0; div_sel = 0; chan_en = 1;
    tick(3);

    pin_in = 1;
    tick(3);
    chk("R2 filt_lvl at 3", filt_lvl, 1); chk("R2 no strobe at 3", cap_strobe, 0);
    tick(1);
    chk("R2 strobe at 4", cap_strobe, 1); chk("R5 rise edge_evt", edge_evt, 1);
    tick(1);
    chk("R5 edge_evt one clock", edge_evt, 0); chk("R9 strobe one clock", cap_strobe, 0);

    pin_in = 0;
    tick(4);
    chk("R5 fall edge_evt", edge_evt, 1); chk("R6 falling ignored when rising", cap_strobe, 0);

    pol_fall = 1;
    pin_in = 1;
    tick(4);
    chk("R5 edge_evt pol1", edge_evt, 1); chk("R6 rising ignored when falling", cap_strobe, 0);
    pin_in = 0;
    tick(4);
    chk("R6 falling strobe", cap_strobe, 1);

    pol_fall = 0; flt_cfg = 4'd3;
    tick(4);
    pin_in = 1;
    tick(3);
    pin_in = 0;
    for (int k = 0; k < 8; k++) begin
      chk("R3 glitch rejected filt", filt_lvl, 0);
      chk("R3 glitch rejected edge", edge_evt, 0);
      tick(1);
    end
    pin_in = 1;
    tick(5);
    chk("R3 not yet at N+1-1", filt_lvl, 0);
    tick(1);
    chk("R3 accepted at N+1", filt_lvl, 1);
    tick(1);
    chk("R3 strobe after filter", cap_strobe, 1);

    flt_cfg = 4'd1; smp_tick = 0; pin_in = 0;
    for (int k = 0; k < 8; k++) tick(1);
    chk("R4 held without ticks", filt_lvl, 1);
    smp_tick = 1;
    tick(1);
    chk("R4 one tick not enough", filt_lvl, 1);
    tick(1);
    chk("R3 second tick accepts", filt_lvl, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule